// File: doc/BRIEF.md
# Signed Multicycle Multiply Sequencer

This block multiplies two signed two's-complement words of a parameterised width (16 bits by default) and returns a double-width signed product. It is a serial engine: one pulse on `start` latches both operands. The block then spends one clock per multiplier bit and updates a partial product in each of those clocks. After the stepping, it writes the product out in two halves and settles four condition flags for the result.

Each step looks at the current low multiplier bit together with the bit that was shifted out on the step before. From that pair it adds the multiplicand, subtracts it, or leaves the partial product alone. It then shifts the partial product and the multiplier right as one joined register. The partial product carries one guard bit, so the most negative operand is handled without overflow.

The surrounding control issues `start` while `busy` is low and waits for the one-cycle `done` pulse. It then reads `prod_hi`, `prod_lo` and the flags, which hold their values until the next multiply writes them.

Top module: `mulseq_top`

## Requirements
- R1: After `done`, {`prod_hi`,`prod_lo`} equals the signed product of `mcand` and `mplier` as sampled at the accepted `start`, as a 2W-bit two's-complement value. `prod_hi` holds bits 2W-1..W and `prod_lo` holds bits W-1..0.
- R2: `start` is accepted at a clock edge where `busy` is low. From the next cycle, `busy` is high. `done` is first seen W+3 cycles after the accepting edge.
- R3: `done` is high for exactly one cycle per multiply, and `busy` falls together with it.
- R4: A `start` pulse while `busy` is high is ignored. The running multiply keeps its operands and its timing.
- R5: `flag_n` equals bit 2W-1 of the product, which is the MSB of `prod_hi`.
- R6: `flag_z` is 1 exactly when the whole 2W-bit product is zero.
- R7: `flag_v` is 0 after every multiply.
- R8: `flag_c` is 0 when every bit of `prod_hi` equals bit W-1 of `prod_lo`, so that the product fits in a W-bit signed word. Otherwise `flag_c` is 1.
- R9: The most negative operand times itself gives +2^(2W-2): `prod_hi` = 0100..0, `prod_lo` = 0, and `flag_c` = 1.
- R10: The upper word is written one cycle before the lower word. W+2 cycles after the accepting edge, `prod_hi` already shows the new value while `prod_lo` still shows the previous one.
- R11: While idle, `prod_hi`, `prod_lo` and the flags keep their values. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiply (accepted only while idle) |
| mcand | input | W | Multiplicand, signed |
| mplier | input | W | Multiplier, signed |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_hi | output | W | Upper half of the product |
| prod_lo | output | W | Lower half of the product |
| flag_n | output | 1 | Product negative |
| flag_z | output | 1 | Product zero |
| flag_v | output | 1 | Overflow, always cleared |
| flag_c | output | 1 | Product does not fit in W signed bits |

## Verification
The hard cases are inside the add/subtract recoding. These are a multiplicand at the most negative value, where only the guard bit keeps the subtraction correct, and multipliers whose bit pairs call for an add directly after a subtract or the reverse. Sign-boundary products also matter, because `flag_c` toggles on them. A second instance built at width 5 is swept over all 1024 operand pairs, which reaches every such recoding path and flag boundary. The 16-bit instance runs directed extremes and a seeded random batch. One multiply is overlapped by a second `start` that carries different operands, and the ordered write of the two product words is observed between the two store cycles.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_STEP = 3'd1,
      ST_HI   = 3'd2,
      ST_LO   = 3'd3,
      ST_FIN  = 3'd4
   } mseq_state_e;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_ADD  = 2'd1,
      OP_SUB  = 2'd2
   } recode_op_e;

   // bit pair {current low multiplier bit, bit shifted out last step}
   function automatic recode_op_e recode(input logic cur, input logic prev);
      case ({cur, prev})
         2'b10:   recode = OP_SUB;
         2'b01:   recode = OP_ADD;
         default: recode = OP_NONE;
      endcase
   endfunction

endpackage

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
   import mulseq_pkg::*;
#(
   parameter int W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step_en,
   output logic store_hi,
   output logic store_lo,
   output logic done,
   output logic busy
);
   localparam int CW = $clog2(W + 1);

   mseq_state_e     state;
   logic [CW-1:0]   steps_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         steps_left <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state      <= ST_STEP;
               steps_left <= CW'(W);
            end
            ST_STEP: begin
               steps_left <= steps_left - CW'(1);
               if (steps_left == CW'(1)) state <= ST_HI;
            end
            ST_HI:   state <= ST_LO;
            ST_LO:   state <= ST_FIN;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      load     = (state == ST_IDLE) && start;
      step_en  = (state == ST_STEP);
      store_hi = (state == ST_HI);
      store_lo = (state == ST_LO);
      done     = (state == ST_FIN);
      busy     = (state != ST_IDLE);
   end

endmodule

// File: rtl/mulseq_dp.sv
module mulseq_dp
   import mulseq_pkg::*;
#(
   parameter int W            = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step_en,
   input  logic [W-1:0] mcand_in,
   input  logic [W-1:0] mplier_in,
   output logic [W-1:0] upper_word,
   output logic [W-1:0] lower_word
);
   localparam int AW = W + 1;   // guard bit for the most negative operand

   logic [AW-1:0] acc;
   logic [W-1:0]  mq;
   logic          tail;
   logic [W-1:0]  mc_q;
   logic [AW-1:0] mc_ext;
   logic [AW-1:0] sum;
   recode_op_e    op;

   assign mc_ext = {mc_q[W-1], mc_q};
   assign op     = recode(mq[0], tail);

   generate
      if (SHARED_ADDER) begin : g_shared
         logic          inv;
         logic [AW-1:0] operand;
         always_comb begin
            inv     = (op == OP_SUB);
            operand = (op == OP_NONE) ? '0 : (inv ? ~mc_ext : mc_ext);
            sum     = acc + operand + AW'(inv);
         end
      end else begin : g_split
         logic [AW-1:0] plus, minus;
         always_comb begin
            plus  = acc + mc_ext;
            minus = acc - mc_ext;
            case (op)
               OP_ADD:  sum = plus;
               OP_SUB:  sum = minus;
               default: sum = acc;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         mq   <= '0;
         tail <= 1'b0;
         mc_q <= '0;
      end else if (load) begin
         acc  <= '0;
         mq   <= mplier_in;
         tail <= 1'b0;
         mc_q <= mcand_in;
      end else if (step_en) begin
         acc  <= {sum[AW-1], sum[AW-1:1]};
         mq   <= {sum[0], mq[W-1:1]};
         tail <= mq[0];
      end
   end

   assign upper_word = acc[W-1:0];
   assign lower_word = mq;

endmodule

// File: rtl/mulseq_flags.sv
module mulseq_flags #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture,
   input  logic [W-1:0] upper_word,
   input  logic [W-1:0] lower_word,
   output logic         flag_n,
   output logic         flag_z,
   output logic         flag_v,
   output logic         flag_c
);
   logic [W-1:0] same_as_sign;

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_fit
         assign same_as_sign[i] = (upper_word[i] == lower_word[W-1]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_n <= 1'b0;
         flag_z <= 1'b0;
         flag_v <= 1'b0;
         flag_c <= 1'b0;
      end else if (capture) begin
         flag_n <= upper_word[W-1];
         flag_z <= ~|{upper_word, lower_word};
         flag_v <= 1'b0;
         flag_c <= ~&same_as_sign;
      end
   end

endmodule

// File: rtl/mulseq_top.sv
module mulseq_top #(
   parameter int W            = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] mcand,
   input  logic [W-1:0] mplier,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] prod_hi,
   output logic [W-1:0] prod_lo,
   output logic         flag_n,
   output logic         flag_z,
   output logic         flag_v,
   output logic         flag_c
);
   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("mulseq_top: W must lie in 2..32");
      end
   endgenerate

   logic         load, step_en, store_hi, store_lo;
   logic [W-1:0] upper_word, lower_word;

   mulseq_ctrl #(.W(W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .load     (load),
      .step_en  (step_en),
      .store_hi (store_hi),
      .store_lo (store_lo),
      .done     (done),
      .busy     (busy)
   );

   mulseq_dp #(.W(W), .SHARED_ADDER(SHARED_ADDER)) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .step_en    (step_en),
      .mcand_in   (mcand),
      .mplier_in  (mplier),
      .upper_word (upper_word),
      .lower_word (lower_word)
   );

   mulseq_flags #(.W(W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (store_lo),
      .upper_word (upper_word),
      .lower_word (lower_word),
      .flag_n     (flag_n),
      .flag_z     (flag_z),
      .flag_v     (flag_v),
      .flag_c     (flag_c)
   );

   // R10: upper word written first, lower word one cycle later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_hi <= '0;
         prod_lo <= '0;
      end else begin
         if (store_hi) prod_hi <= upper_word;
         if (store_lo) prod_lo <= lower_word;
      end
   end

endmodule

// File: rtl/mulseq_chk.sv
module mulseq_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic [W-1:0] prod_hi,
   input logic [W-1:0] prod_lo,
   input logic         flag_n,
   input logic         flag_z,
   input logic         flag_v,
   input logic         flag_c
);
   logic [7:0] busy_cycles;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_cycles <= '0;
      else if (!busy) busy_cycles <= '0;
      else            busy_cycles <= busy_cycles + 8'd1;
   end

   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_cycles == 8'(W + 2)));

   a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   a_r5_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flag_n == prod_hi[W-1]));

   a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flag_z == (prod_hi == '0 && prod_lo == '0)));

   a_r7_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !flag_v);

   a_r8_carry_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flag_c == (prod_hi != {W{prod_lo[W-1]}})));

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo) &&
                             $stable(flag_n) && $stable(flag_z) && $stable(flag_c)));

endmodule

bind mulseq_top mulseq_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .prod_hi (prod_hi),
   .prod_lo (prod_lo),
   .flag_n  (flag_n),
   .flag_z  (flag_z),
   .flag_v  (flag_v),
   .flag_c  (flag_c)
);

// File: tb/sim_mulseq_top.sv
`timescale 1ns/1ps
module sim_mulseq_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // 16-bit instance
   logic        st0 = 1'b0;
   logic [15:0] mc0 = '0, mp0 = '0;
   logic        busy0, done0, n0, z0, v0, c0;
   logic [15:0] hi0, lo0;

   mulseq_top #(.W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .start(st0), .mcand(mc0), .mplier(mp0),
      .busy(busy0), .done(done0), .prod_hi(hi0), .prod_lo(lo0),
      .flag_n(n0), .flag_z(z0), .flag_v(v0), .flag_c(c0));

   // 5-bit instance for the exhaustive sweep
   logic       st1 = 1'b0;
   logic [4:0] mc1 = '0, mp1 = '0;
   logic       busy1, done1, n1, z1, v1, c1;
   logic [4:0] hi1, lo1;

   mulseq_top #(.W(5)) u1 (
      .clk(clk), .rst_n(rst_n), .start(st1), .mcand(mc1), .mplier(mp1),
      .busy(busy1), .done(done1), .prod_hi(hi1), .prod_lo(lo1),
      .flag_n(n1), .flag_z(z1), .flag_v(v1), .flag_c(c1));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
         end
      end
   end

   // one 16-bit multiply; optional overlapping start carrying other operands
   task automatic run16(input logic [15:0] a, input logic [15:0] b, input bit overlap);
      logic signed [31:0] p;
      logic [15:0] old_lo;
      logic [15:0] eh, el;
      int n;
      p  = $signed(a) * $signed(b);
      eh = p[31:16];
      el = p[15:0];
      old_lo = lo0;
      @(negedge clk);
      mc0 = a; mp0 = b; st0 = 1'b1;
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            st0 = 1'b0;
            chk(busy0 == 1'b1, "R2", "busy after accept", busy0, 1);
         end
         if (overlap && n == 4) begin
            mc0 = ~a; mp0 = b ^ 16'h5a5a; st0 = 1'b1;   // R4 stimulus
         end
         if (overlap && n == 5) st0 = 1'b0;
         if (n == 18 && el != old_lo) begin
            chk(hi0 == eh, "R10", "upper word first", hi0, eh);
            chk(lo0 == old_lo, "R10", "lower word not yet", lo0, old_lo);
         end
         if (done0 || n > 60) break;
      end
      chk(n == 19, "R2", "latency", n, 19);
      chk({hi0, lo0} == p, overlap ? "R4" : "R1", "product", {hi0, lo0}, p);
      chk(n0 == p[31], "R5", "flag_n", n0, p[31]);
      chk(z0 == (p == 0), "R6", "flag_z", z0, (p == 0));
      chk(v0 == 1'b0, "R7", "flag_v", v0, 0);
      chk(c0 == (eh != {16{el[15]}}), "R8", "flag_c", c0, (eh != {16{el[15]}}));
      @(negedge clk);
      chk(done0 == 1'b0 && busy0 == 1'b0, "R3", "done one cycle", {done0, busy0}, 0);
      repeat (3) @(negedge clk);
      chk({hi0, lo0} == p, "R11", "hold while idle", {hi0, lo0}, p);
   endtask

   task automatic run5(input logic [4:0] a, input logic [4:0] b);
      logic signed [9:0] p;
      int n;
      p = $signed(a) * $signed(b);
      @(negedge clk);
      mc1 = a; mp1 = b; st1 = 1'b1;
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (n == 1) st1 = 1'b0;
         if (done1 || n > 40) break;
      end
      chk(n == 8, "R2", "latency w5", n, 8);
      chk({hi1, lo1} == p, "R1", "product w5", {hi1, lo1}, p);
      chk(n1 == p[9] && z1 == (p == 0), "R5", "flags n/z w5 (R6)", {n1, z1}, {p[9], (p == 0)});
      chk(c1 == (p[9:5] != {5{p[4]}}) && !v1, "R8", "flags c/v w5 (R7)", {c1, v1}, {(p[9:5] != {5{p[4]}}), 1'b0});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy0 && !done0 && hi0 == 0 && lo0 == 0 && !n0 && !z0 && !v0 && !c0,
          "R11", "reset state", {busy0, done0, hi0, lo0}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: most negative squared
      run16(16'h8000, 16'h8000, 1'b0);
      chk(hi0 == 16'h4000 && lo0 == 16'h0000 && c0, "R9", "min*min", {hi0, lo0, c0}, {32'h4000_0000, 1'b1});
      run16(16'h8000, 16'h7fff, 1'b0);
      run16(16'h7fff, 16'h8000, 1'b0);
      run16(16'h0000, 16'h1234, 1'b0);
      run16(16'hffff, 16'hffff, 1'b0);
      run16(16'hffff, 16'h8000, 1'b0);
      run16(16'h0003, 16'h5555, 1'b0);
      run16(16'haaaa, 16'h5555, 1'b0);
      run16(16'h00ff, 16'h0080, 1'b0);
      run16(16'hff80, 16'h0001, 1'b0);
      run16(16'h1234, 16'h5678, 1'b1);   // R4 overlapping start
      for (int k = 0; k < 300; k++) begin
         logic [15:0] ra, rb;
         ra = 16'($urandom);
         rb = 16'($urandom);
         run16(ra, rb, (k % 10) == 0);
      end

      // exhaustive sweep at width 5
      for (int a = -16; a < 16; a++) begin
         for (int b = -16; b < 16; b++) begin
            run5(5'(a), 5'(b));
         end
      end
      summary();
   end
endmodule